// File: doc/BRIEF.md
# FIFO Read-Side Strobe Controller

This block sits on the consumer side of an asynchronous-style handshake FIFO, one that advances its read pointer on a shift-out strobe and reports data through an output-ready flag. The controller produces that strobe so that the FIFO always recognises it. Every strobe is held high until the FIFO acknowledges it by lowering output-ready. The FIFO's output word is captured on the rising edge of the strobe into a one-word holding register. That register drives a valid/ready stream toward a downstream sink.

Two read policies can be switched on at run time, alone or together. The guard policy delays the first strobe after the FIFO has been empty by a fixed number of cycles. This keeps the strobe out of the window just after output-ready first rises, where the FIFO may not see it. Later reads run back to back. The threshold policy does not start a read session until the FIFO holds more than half its depth. Once started, the session keeps reading until the FIFO is empty. The controller depends on the FIFO's fill level for both policies and on output-ready for the handshake.

Top module: `fifo_read_strobe_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the strobe is low and the stream output is not valid. Reset arms the guard, so the first read after reset is treated as a read from empty.
- R2: A strobe rises only at a clock edge where output-ready is sampled high. With no policy active, the strobe rises at the first edge that sees output-ready high, provided the holding register has room.
- R3: Once high, the strobe stays high at every edge where output-ready is high. It falls at the first edge where output-ready is sampled low.
- R4: At the edge where the strobe rises, the word present on the FIFO data input is loaded into the holding register. The sink receives the words in FIFO order, each exactly once.
- R5: No strobe rises at an edge where the holding register is valid and the sink's ready is low.
- R6: With the guard enabled (policy bit 0 = 1), the first strobe after the fill level has been seen at zero rises GUARD_CYC cycles later than it would with no policy. That is GUARD_CYC+1 edges after output-ready first rises.
- R7: The guard applies to that first word only. The next strobe rises at the first edge after output-ready returns high, as in R2.
- R8: With the threshold enabled (policy bit 1 = 1), no strobe rises until the fill level is sampled above DEPTH/2. The session then continues until the fill level is sampled at zero.
- R9: While the stream output is valid and ready is low, valid stays high and the data stays unchanged.
- R10: The two policy bits act independently. With both set, a read session from empty still waits for the fill level to exceed DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Bit 0 enables the guard delay, bit 1 enables the half-full threshold |
| or_flag | input | 1 | Output-ready flag from the FIFO |
| fifo_data | input | DATA_W | FIFO output word |
| fill_level | input | LVL_W | Number of words held by the FIFO |
| so_strobe | output | 1 | Shift-out strobe to the FIFO (registered) |
| m_data | output | DATA_W | Stream data toward the sink |
| m_valid | output | 1 | Stream valid |
| m_ready | input | 1 | Stream ready from the sink |

## Verification
The bench builds the block with DATA_W = 8, DEPTH = 8 and GUARD_CYC = 3. With these values a behavioural FIFO model fills to full and drains within a few dozen cycles, so the full-FIFO and empty-FIFO boundaries are reached many times in each run. It sweeps all four policy codes against three sink-ready patterns, each with two bursts. The second burst re-enters from empty, which makes the guard re-arm and the threshold session restart observable. The short guard lets the exact strobe latency be predicted arithmetically as GUARD_CYC+1 edges. The threshold start is predicted at exactly DEPTH/2+1 words.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic {
    SO_IDLE = 1'b0,
    SO_WAIT = 1'b1
  } so_state_t;

  localparam int POL_GUARD = 0;
  localparam int POL_THRESH = 1;
endpackage

// File: rtl/rsc_guard.sv
module rsc_guard #(
  parameter int GUARD_CYC = 4,
  parameter int CW = $clog2(GUARD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fifo_empty,
  input  logic or_flag,
  input  logic launch,
  output logic permit
);
  logic          armed;
  logic [CW-1:0] cnt;
  logic          done;

  assign done   = (cnt == CW'(GUARD_CYC));
  assign permit = !en || !armed || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (fifo_empty) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (launch) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && or_flag && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: while armed and the window has not run out, no strobe may start
  p_guard_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (en && armed && !done) |-> !launch);

  // R7: after the first launch from empty the guard stops delaying
  p_guard_disarm_r7: assert property (@(posedge clk) disable iff (rst)
    (launch && !fifo_empty) |=> !armed);
endmodule

// File: rtl/rsc_thresh.sv
module rsc_thresh #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  output logic             permit
);
  localparam int HALF = DEPTH / 2;

  logic active;
  logic above;

  assign above  = (level > LVL_W'(HALF));
  assign permit = !en || active || above;

  always_ff @(posedge clk) begin
    if (rst)                  active <= 1'b0;
    else if (level == '0)     active <= 1'b0;
    else if (above)           active <= 1'b1;
  end

  // R8: a session only opens after the level was seen above half
  p_session_open_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> ($past(level) > LVL_W'(HALF)));
endmodule

// File: rtl/rsc_strobe.sv
module rsc_strobe
  import rsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic or_flag,
  input  logic permit,
  input  logic room,
  output logic launch,
  output logic so
);
  so_state_t st;

  assign so     = (st == SO_WAIT);
  assign launch = (st == SO_IDLE) && or_flag && permit && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SO_IDLE;
    end else begin
      case (st)
        SO_IDLE: if (launch)   st <= SO_WAIT;
        SO_WAIT: if (!or_flag) st <= SO_IDLE;
        default:               st <= SO_IDLE;
      endcase
    end
  end

  // R2: strobe rises only after output-ready was seen high
  p_rise_needs_or_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(so) |-> $past(or_flag));

  // R3: held while unacknowledged, released once acknowledged
  p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
    (so && or_flag) |=> so);
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (so && !or_flag) |=> !so);
endmodule

// File: rtl/rsc_hold.sv
module rsc_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              m_ready,
  output logic              room,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid
);
  assign room = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R9: a stalled word is held unchanged
  p_stall_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5: a stalled holding register blocks any new capture
  p_no_load_stalled_r5: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !load);
endmodule

// File: rtl/fifo_read_strobe_ctrl.sv
module fifo_read_strobe_ctrl
  import rsc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int GUARD_CYC = 4,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policy,
  input  logic              or_flag,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [LVL_W-1:0]  fill_level,
  output logic              so_strobe,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready
);
  logic launch;
  logic room;
  logic guard_ok;
  logic thr_ok;
  logic fifo_empty;

  assign fifo_empty = (fill_level == '0);

  rsc_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .en         (policy[POL_GUARD]),
    .fifo_empty (fifo_empty),
    .or_flag    (or_flag),
    .launch     (launch),
    .permit     (guard_ok)
  );

  rsc_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_thresh (
    .clk    (clk),
    .rst    (rst),
    .en     (policy[POL_THRESH]),
    .level  (fill_level),
    .permit (thr_ok)
  );

  rsc_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .or_flag (or_flag),
    .permit  (guard_ok && thr_ok),
    .room    (room),
    .launch  (launch),
    .so      (so_strobe)
  );

  rsc_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .din     (fifo_data),
    .m_ready (m_ready),
    .room    (room),
    .m_data  (m_data),
    .m_valid (m_valid)
  );

  // R4: the word on the FIFO bus at the strobe's rising edge is what is held
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(so_strobe) |-> (m_valid && m_data == $past(fifo_data)));

  // R1: out of reset nothing is strobed or offered
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!so_strobe && !m_valid));
endmodule

// File: tb/test_fifo_read_strobe_ctrl.sv
module test_fifo_read_strobe_ctrl;
  localparam int DW = 8;
  localparam int DEP = 8;
  localparam int GC = 3;
  localparam int LW = $clog2(DEP + 1);
  localparam int HALF = DEP / 2;
  localparam int BW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    policy = 2'b00;
  logic          or_flag = 1'b0;
  logic [DW-1:0] fifo_data = '0;
  logic [LW-1:0] fill_level = '0;
  logic          so_strobe;
  logic [DW-1:0] m_data;
  logic          m_valid;
  logic          m_ready = 1'b0;

  fifo_read_strobe_ctrl #(.DATA_W(DW), .DEPTH(DEP), .GUARD_CYC(GC)) i_fifo_read_strobe_ctrl (
    .clk(clk), .rst(rst), .policy(policy), .or_flag(or_flag),
    .fifo_data(fifo_data), .fill_level(fill_level), .so_strobe(so_strobe),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
  );

  always #5 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] q[$];
  logic active = 1'b0;
  logic pend;
  int run_id, rp, pushed, received, gap, idle, rise_in_burst, or_rise_cyc, fill_seen;
  logic prev_so, prev_valid, prev_ready;
  logic [DW-1:0] prev_data;

  function automatic logic [DW-1:0] word_of(int r, int i);
    return DW'((r * 53 + i * 29 + 7) & 255);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (run %0d)", tag, act, exp, run_id);
    end
  endtask

  function automatic logic ready_pat(int p, int c);
    if (p == 0) return 1'b1;
    if (p == 1) return (c % 3) != 0;
    return (c % 5) < 2;
  endfunction

  always @(negedge clk) begin
    if (active) begin
      fill_seen = q.size();
      // strobe rise checks
      if (so_strobe && !prev_so) begin
        chk(!(prev_valid && !prev_ready), "R5", 1, 0);
        if (rise_in_burst == 0) begin
          if (policy == 2'd0) chk(cyc - or_rise_cyc == 1, "R2", cyc - or_rise_cyc, 1);
          if (policy == 2'd1) chk(cyc - or_rise_cyc == GC + 1, "R6", cyc - or_rise_cyc, GC + 1);
          if (policy == 2'd2) chk(fill_seen == HALF + 1, "R8", fill_seen, HALF + 1);
          if (policy == 2'd3) chk(fill_seen > HALF, "R10", fill_seen, HALF + 1);
        end else if (rise_in_burst == 1 && policy == 2'd1 && rp == 0) begin
          chk(cyc - or_rise_cyc == 1, "R7", cyc - or_rise_cyc, 1);
        end
        rise_in_burst++;
      end
      // strobe hold / release
      if (prev_so) begin
        if (or_flag) chk(so_strobe, "R3", so_strobe, 1);
        else         chk(!so_strobe, "R3", so_strobe, 0);
      end
      // stall stability
      if (prev_valid && !prev_ready)
        chk(m_valid && m_data == prev_data, "R9", m_data, prev_data);
      // delivery
      if (prev_valid && prev_ready) begin
        chk(prev_data == word_of(run_id, received), "R4", prev_data, word_of(run_id, received));
        received++;
      end
      prev_so = so_strobe;
      prev_valid = m_valid;
      prev_data = m_data;
      m_ready = ready_pat(rp, cyc);
      prev_ready = m_ready;
      // FIFO model
      if (so_strobe && or_flag) begin
        or_flag = 1'b0;
        pend = 1'b1;
      end else if (!so_strobe && pend) begin
        void'(q.pop_front());
        pend = 1'b0;
      end else if (!so_strobe && !or_flag && !pend && q.size() > 0) begin
        or_flag = 1'b1;
        or_rise_cyc = cyc;
      end
      // producer
      if (pushed == BW && received == BW) begin
        if (idle < 4) idle++;
        else if (q.size() == 0) begin
          pushed = BW + 1;
          rise_in_burst = 0;
        end
      end
      if (pushed != BW) begin
        if (gap > 0) gap--;
        else if (q.size() < DEP && pushed < 2 * BW + 1) begin
          q.push_back(word_of(run_id, pushed > BW ? pushed - 1 : pushed));
          pushed++;
          gap = 1;
        end
      end
      fifo_data = q.size() > 0 ? q[0] : '0;
      fill_level = LW'(q.size());
    end
  end

  task automatic do_run(input int pol, input int pat, input int id);
    int t;
    @(negedge clk); #1;
    active = 1'b0;
    rst = 1'b1;
    policy = 2'(pol);
    rp = pat; run_id = id;
    q.delete();
    pend = 1'b0; or_flag = 1'b0; fifo_data = '0; fill_level = '0;
    pushed = 0; received = 0; gap = 0; idle = 0; rise_in_burst = 0; or_rise_cyc = 0;
    prev_so = 1'b0; prev_valid = 1'b0; prev_ready = 1'b0; prev_data = '0;
    m_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(!so_strobe && !m_valid, "R1", {so_strobe, m_valid}, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!so_strobe && !m_valid, "R1", {so_strobe, m_valid}, 0);
    #1 active = 1'b1;
    t = 0;
    while (received < 2 * BW && t < 3000) begin
      @(negedge clk);
      t++;
    end
    #1 active = 1'b0;
    chk(received == 2 * BW, "R4", received, 2 * BW);
  endtask

  initial begin
    int id;
    id = 0;
    for (int pol = 0; pol < 4; pol++) begin
      for (int pat = 0; pat < 3; pat++) begin
        do_run(pol, pat, id);
        id++;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1500000;
    nvec++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule